// File: doc/BRIEF.md
# Low-Power Mode Controller

This block manages the sleep states of a small 8-bit microcontroller core. Software enters a state with a single-cycle write of a two-bit mode field. In the light sleep state the core clock stops and the oscillator keeps running. In the deep sleep state both the core clock and the oscillator stop. A dedicated input pin forces a third state, a pin-held deep sleep. The block drives three outputs: a core clock enable, an oscillator enable and a port-float enable. The port-float enable is active in either deep state when the float configuration input is set.

Six interrupt request lines wake the core from the two states that software entered. Only reset clears the pin-held state. After a wake from deep sleep, the core clock stays off for a programmable number of cycles while the oscillator stabilises. On each wake the block reports on a two-bit code whether the core should restart at address 0, take an interrupt vector, or continue at the next instruction.

The state machine has five states:
- `ST_RUN`: normal operation.
- `ST_IDLE`: light sleep.
- `ST_SPD`: software deep sleep.
- `ST_HPD`: pin-held deep sleep.
- `ST_SETTLE`: oscillator settling.

It has these transitions:
- `ST_RUN` to `ST_SPD` on a write with the deep bit set.
- `ST_RUN` to `ST_IDLE` on a write with only the light bit set.
- `ST_IDLE` to `ST_RUN` on any request.
- `ST_SPD` to `ST_SETTLE` on any request.
- `ST_SETTLE` to `ST_RUN` when the settle count expires.
- `ST_RUN`, `ST_IDLE`, `ST_SPD` and `ST_SETTLE` to `ST_HPD` when the synchronised pin is high.
- Any state to `ST_RUN` on reset.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the block is in `ST_RUN`, with `cpu_clk_en`=1, `osc_en`=1, `port_float`=0, `resume_valid`=0 and `resume_kind`=00 (restart at address 0).
- R2: A write in `ST_RUN` is a cycle with `mode_wr`=1. Bit 0 of `mode_wdata` requests light sleep and bit 1 requests deep sleep. Deep sleep wins when both bits are set. A write of 00 changes nothing. The new state shows from the next cycle.
- R3: In `ST_IDLE`, `cpu_clk_en`=0, `osc_en`=1 and `port_float`=0.
- R4: In `ST_SPD` and `ST_HPD`, `cpu_clk_en`=0 and `osc_en`=0, and `port_float` follows `float_cfg`.
- R5: `hpd_pin` passes through a two-flop synchroniser. A pin sampled high at one clock edge moves the block to `ST_HPD` at the third edge. This applies from any other state and overrides a mode write or a wake in that cycle.
- R6: Only reset leaves `ST_HPD`. Interrupt requests and release of the pin have no effect.
- R7: In `ST_IDLE`, a cycle with any `irq_req` bit high returns the block to `ST_RUN` at the next edge. `resume_valid` is 1 for exactly that first `ST_RUN` cycle.
- R8: In `ST_SPD`, a request turns `osc_en` on at the next edge. `cpu_clk_en` then stays 0 for `settle_cycles`+1 cycles, and `resume_valid` pulses with the first `ST_RUN` cycle.
- R9: At a wake, `resume_kind` becomes 01 (vector) if any bit of `irq_req & irq_en` is set, and 10 (continue) otherwise. It holds that value until the next wake or reset.
- R10: Reset asserted in any state, including `ST_HPD`, restores the R1 outputs at once.
- R11: A mode write in any state other than `ST_RUN` is ignored, and an interrupt request in `ST_RUN` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode field: bit 0 light sleep, bit 1 deep sleep |
| float_cfg | input | 1 | Float ports in the deep states |
| hpd_pin | input | 1 | Asynchronous pin-held sleep request |
| irq_req | input | N_SRC | Interrupt request lines (wake sources) |
| irq_en | input | N_SRC | Interrupt enable per source |
| settle_cycles | input | CNT_W | Settling length after deep sleep |
| cpu_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| port_float | output | 1 | Port float enable |
| resume_valid | output | 1 | One-cycle pulse on return to run |
| resume_kind | output | 2 | 00 restart, 01 vector, 10 continue |

## Verification
The bench targets four cases where the priority rules matter.

- A mode write with both bits set must enter deep sleep. A swapped priority would leave the oscillator running.
- A pin rising in the same cycle as a mode write must end in the pin-held state. The same holds when the pin rises during settling. A design with the priority reversed, or with one synchroniser stage missing, would differ from the model by one cycle or by state.
- Requests and pin release while in `ST_HPD` must not wake the core. A leaky exit would turn the clock back on.
- The settle length is checked at zero and at a non-zero value. An off-by-one in the counter would raise `cpu_clk_en` a cycle early or late.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_IDLE   = 3'd1,
        ST_SPD    = 3'd2,
        ST_HPD    = 3'd3,
        ST_SETTLE = 3'd4
    } pmc_state_e;

    typedef enum logic [1:0] {
        RK_RESTART  = 2'b00,
        RK_VECTOR   = 2'b01,
        RK_CONTINUE = 2'b10
    } resume_kind_e;
endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pmc_wake_eval.sv
module pmc_wake_eval #(
    parameter int N_SRC = 6
) (
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en,
    output logic             any_wake,
    output logic             take_vector
);
    logic [N_SRC-1:0] hit;

    generate
        for (genvar i = 0; i < N_SRC; i++) begin : g_src
            assign hit[i] = req[i] & en[i];
        end
    endgenerate

    assign any_wake    = |req;
    assign take_vector = |hit;
endmodule

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int N_SRC       = 6,
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wr,
    input  logic [1:0]       mode_wdata,
    input  logic             float_cfg,
    input  logic             hpd_pin,
    input  logic [N_SRC-1:0] irq_req,
    input  logic [N_SRC-1:0] irq_en,
    input  logic [CNT_W-1:0] settle_cycles,
    output logic             cpu_clk_en,
    output logic             osc_en,
    output logic             port_float,
    output logic             resume_valid,
    output logic [1:0]       resume_kind
);
    localparam int IDLE_BIT = 0;
    localparam int DEEP_BIT = 1;

    pmc_state_e   state, nxt;
    resume_kind_e kind_q;
    logic         hpd_sync, any_wake, take_vector, tmr_done;
    logic         tmr_load, kind_capture, valid_d, deep_state;

    pmc_sync #(.STAGES(SYNC_STAGES)) u_hpd_sync (
        .clk(clk), .rst_n(rst_n), .d(hpd_pin), .q(hpd_sync)
    );

    pmc_wake_eval #(.N_SRC(N_SRC)) u_wake (
        .req(irq_req), .en(irq_en), .any_wake(any_wake), .take_vector(take_vector)
    );

    pmc_settle_timer #(.CNT_W(CNT_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(settle_cycles), .done(tmr_done)
    );

    // Next-state logic: pin-held sleep overrides everything but reset.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN: begin
                if (hpd_sync)                           nxt = ST_HPD;
                else if (mode_wr && mode_wdata[DEEP_BIT]) nxt = ST_SPD;
                else if (mode_wr && mode_wdata[IDLE_BIT]) nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (hpd_sync)      nxt = ST_HPD;
                else if (any_wake) nxt = ST_RUN;
            end
            ST_SPD: begin
                if (hpd_sync)      nxt = ST_HPD;
                else if (any_wake) nxt = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (hpd_sync)      nxt = ST_HPD;
                else if (tmr_done) nxt = ST_RUN;
            end
            ST_HPD:  nxt = ST_HPD;
            default: nxt = ST_RUN;
        endcase
    end

    assign tmr_load     = (state == ST_SPD) && !hpd_sync && any_wake;
    assign kind_capture = ((state == ST_IDLE) || (state == ST_SPD)) && !hpd_sync && any_wake;
    assign valid_d      = (nxt == ST_RUN) && ((state == ST_IDLE) || (state == ST_SETTLE));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Wake report register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q       <= RK_RESTART;
            resume_valid <= 1'b0;
        end else begin
            resume_valid <= valid_d;
            if (kind_capture) kind_q <= take_vector ? RK_VECTOR : RK_CONTINUE;
        end
    end

    // Output decode
    always_comb begin
        deep_state = 1'b0;
        cpu_clk_en = 1'b0;
        osc_en     = 1'b1;
        unique case (state)
            ST_RUN:    cpu_clk_en = 1'b1;
            ST_IDLE:   osc_en     = 1'b1;
            ST_SPD:    begin osc_en = 1'b0; deep_state = 1'b1; end
            ST_HPD:    begin osc_en = 1'b0; deep_state = 1'b1; end
            ST_SETTLE: osc_en     = 1'b1;
            default:   cpu_clk_en = 1'b1;
        endcase
        port_float = deep_state && float_cfg;
    end

    assign resume_kind = kind_q;

    a_r2_deep_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !hpd_sync && mode_wr && mode_wdata[DEEP_BIT]) |=> (state == ST_SPD));
    a_r5_pin_overrides: assert property (@(posedge clk) disable iff (!rst_n)
        (hpd_sync && state != ST_HPD) |=> (state == ST_HPD));
    a_r6_hpd_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HPD) |=> (state == ST_HPD));
    a_r7_idle_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && any_wake && !hpd_sync) |=> (resume_valid && cpu_clk_en));
    a_r8_hold_while_counting: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SETTLE && !tmr_done && !hpd_sync) |=> (state == ST_SETTLE && !cpu_clk_en));
    a_r8_valid_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        resume_valid |-> (state == ST_RUN));
    a_r11_no_entry_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |=> (state == ST_IDLE || state == ST_RUN || state == ST_HPD));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N_SRC = 6;
    localparam int CNT_W = 8;
    localparam int WD_LIMIT = 20000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             mode_wr;
    logic [1:0]       mode_wdata;
    logic             float_cfg;
    logic             hpd_pin;
    logic [N_SRC-1:0] irq_req;
    logic [N_SRC-1:0] irq_en;
    logic [CNT_W-1:0] settle_cycles;
    logic             cpu_clk_en, osc_en, port_float, resume_valid;
    logic [1:0]       resume_kind;

    pwr_mode_ctrl #(.N_SRC(N_SRC), .CNT_W(CNT_W), .SYNC_STAGES(2)) i_pwr_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
        .float_cfg(float_cfg), .hpd_pin(hpd_pin), .irq_req(irq_req), .irq_en(irq_en),
        .settle_cycles(settle_cycles), .cpu_clk_en(cpu_clk_en), .osc_en(osc_en),
        .port_float(port_float), .resume_valid(resume_valid), .resume_kind(resume_kind)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: 0 run, 1 light, 2 deep(sw), 3 pin-held, 4 settling
    int    m_state = 0;
    int    m_left  = 0;
    int    m_kind  = 0;
    int    m_valid = 0;
    bit    pin_hist[$] = '{1'b0, 1'b0};
    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    finished = 1'b0;
    string cur_tag  = "R1";

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_left = 0; m_kind = 0; m_valid = 0;
            pin_hist = '{1'b0, 1'b0};
        end else begin
            bit hs;
            bit wake;
            int kind_new;
            hs = pin_hist[0];
            void'(pin_hist.pop_front());
            pin_hist.push_back(hpd_pin);
            wake = (irq_req != '0);
            kind_new = ((irq_req & irq_en) != '0) ? 1 : 2;
            m_valid = 0;
            if (m_state == 3) begin
                m_state = 3;
            end else if (hs) begin
                m_state = 3;
            end else begin
                case (m_state)
                    0: if (mode_wr && mode_wdata[1]) m_state = 2;
                       else if (mode_wr && mode_wdata[0]) m_state = 1;
                    1: if (wake) begin m_state = 0; m_valid = 1; m_kind = kind_new; end
                    2: if (wake) begin m_state = 4; m_left = int'(settle_cycles) + 1; m_kind = kind_new; end
                    4: begin
                        m_left--;
                        if (m_left == 0) begin m_state = 0; m_valid = 1; end
                    end
                    default: m_state = 0;
                endcase
            end
        end
    end

    task automatic chk(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_tag, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (!finished) begin
            bit deep;
            deep = (m_state == 2) || (m_state == 3);
            chk("cpu_clk_en",   int'(cpu_clk_en),   (m_state == 0) ? 1 : 0);
            chk("osc_en",       int'(osc_en),       deep ? 0 : 1);
            chk("port_float",   int'(port_float),   (deep && float_cfg) ? 1 : 0);
            chk("resume_valid", int'(resume_valid), m_valid);
            chk("resume_kind",  int'(resume_kind),  m_kind);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, WD_LIMIT);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_mode(logic [1:0] v);
        mode_wr = 1'b1; mode_wdata = v;
        tick(1);
        mode_wr = 1'b0; mode_wdata = 2'b00;
    endtask

    task automatic pulse_irq(logic [N_SRC-1:0] v);
        irq_req = v;
        tick(1);
        irq_req = '0;
    endtask

    initial begin
        rst_n = 1'b0; mode_wr = 1'b0; mode_wdata = 2'b00; float_cfg = 1'b0;
        hpd_pin = 1'b0; irq_req = '0; irq_en = '0; settle_cycles = '0;
        tick(3);
        rst_n = 1'b1;
        cur_tag = "R1";  tick(3);
        cur_tag = "R3";  write_mode(2'b01); tick(3);
        cur_tag = "R7";  irq_en = 6'b000100; pulse_irq(6'b000100); tick(3);
        cur_tag = "R2";  write_mode(2'b11); tick(2);
        cur_tag = "R4";  float_cfg = 1'b1; tick(2); float_cfg = 1'b0; tick(1);
        cur_tag = "R8";  settle_cycles = 8'd3; irq_en = '0; pulse_irq(6'b100000); tick(8);
        cur_tag = "R9";  write_mode(2'b10); settle_cycles = 8'd0; irq_en = 6'b000001;
        pulse_irq(6'b000011); tick(4);
        cur_tag = "R2";  write_mode(2'b00); tick(2);
        cur_tag = "R11"; pulse_irq(6'b010000); tick(1);
        write_mode(2'b01); write_mode(2'b10); tick(2); pulse_irq(6'b001000); tick(2);
        cur_tag = "R5";  hpd_pin = 1'b1; tick(2); write_mode(2'b01); tick(3);
        cur_tag = "R6";  float_cfg = 1'b1; pulse_irq(6'b111111); hpd_pin = 1'b0; tick(5);
        cur_tag = "R10"; rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(3);
        cur_tag = "R5";  write_mode(2'b01); tick(1); hpd_pin = 1'b1; tick(4);
        hpd_pin = 1'b0; rst_n = 1'b0; tick(1); rst_n = 1'b1; tick(2);
        write_mode(2'b10); settle_cycles = 8'd10; irq_en = 6'b111111;
        pulse_irq(6'b000010); tick(3); hpd_pin = 1'b1; tick(4);
        cur_tag = "R10"; hpd_pin = 1'b0; rst_n = 1'b0; tick(1); rst_n = 1'b1; tick(3);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule